// File: doc/BRIEF.md
# EEPROM Page-Write Memory Model

This block is a clocked, synthesizable stand-in for a byte-wide electrically erasable memory. It has active-low chip-select, output-enable and write-strobe inputs that are sampled on the system clock, and it reads like a static RAM. Bytes written one after another go into a page buffer first, not into the array. Each strobe rearms a byte-load window. When that window runs out with no further strobe, the whole buffered page is programmed into the array in a single fixed-length interval, during which a busy flag stays high.

While the array is programming, a read of the most recently loaded address returns that byte with bit 7 inverted. Software can therefore poll for completion. Writes are refused when:
- output-enable is asserted,
- the supply-good input is low,
- the strobe is too short,
- programming is already in progress.

The load window and the programming time are clock-cycle parameters. They are scaled down from microseconds and milliseconds so that the model simulates quickly.

Top module: `eeprom_page_model`

## Requirements
- R1: After reset, busy is low, the read enable is low and every array byte reads 8'hFF.
- R2: The data output is enabled (dout_en high) only while ce_n=0, oe_n=0 and we_n=1, and it then carries the array byte at addr. Otherwise dout_en is low and dout is 0.
- R3: The write strobe is active while ce_n and we_n are both low. The address is taken in the first sampled cycle of the strobe. The data is taken in the last sampled active cycle.
- R4: Address bits [PAGE_AW-1:0] select the byte inside a page and the upper bits select the page. All bytes accepted in one load window are programmed together. Page bytes that were not loaded keep their earlier contents, and if an offset is loaded twice, the last value is kept.
- R5: The load timer is held at zero while a strobe is active, and it restarts at each accepted byte. busy first reads high BLC_CYC+1 clock cycles after the first sampled cycle with the strobe inactive.
- R6: busy stays high for exactly PROG_CYC cycles, whether 1 or 2^PAGE_AW bytes were loaded. New contents are readable in the first cycle that busy is low.
- R7: While busy is high, a read of the last accepted address returns that byte with bit 7 inverted and bits 6:0 unchanged. Reads of other addresses return the earlier array contents.
- R8: A strobe during which oe_n is sampled low in any cycle is not accepted.
- R9: A strobe that is active for fewer than MIN_PULSE sampled cycles is not accepted.
- R10: A strobe during which supply_ok is sampled low in any cycle is not accepted.
- R11: A strobe that starts or ends while busy is high is not accepted, and last-address state does not change during programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| supply_ok | input | 1 | High when the supply is above the write threshold |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | High when dout is driven (low means released) |
| busy | output | 1 | High during the programming interval |

## Verification
Two functions can fall in the same clock cycle: the array commit at the end of programming, and a polling read of the last loaded address. The bench holds a read of that address through the whole load window and programming interval, checking dout on every cycle. It expects the old byte during the window, the byte with inverted bit 7 for exactly PROG_CYC cycles, and the true byte in the first cycle after busy falls. A second overlap is a strobe that arrives while programming is in progress. The bench judges it by the array contents and by the absence of a later busy period.

// File: rtl/eepm_pkg.sv
package eepm_pkg;
    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } eepm_state_t;

    // Status view of a byte while its page is being programmed
    function automatic byte_t poll_view(input byte_t d);
        return {~d[7], d[6:0]};
    endfunction
endpackage

// File: rtl/eepm_strobe.sv
module eepm_strobe
    import eepm_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int MIN_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              supply_ok,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             din,
    output logic              wr_act,
    output logic              ld_vld,
    output logic [ADDR_W-1:0] ld_addr,
    output byte_t             ld_data
);
    localparam int LW = $clog2(MIN_PULSE + 1);

    logic          act_q;
    logic          spoil_q;
    logic [LW-1:0] len_q;
    logic          hazard;

    assign wr_act = ~ce_n & ~we_n;
    assign hazard = ~oe_n | ~supply_ok | busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            spoil_q <= 1'b0;
            len_q   <= '0;
            ld_addr <= '0;
            ld_data <= '0;
        end else begin
            act_q <= wr_act;
            if (wr_act) begin
                ld_data <= din;
                if (!act_q) begin
                    ld_addr <= addr;
                    len_q   <= LW'(1);
                    spoil_q <= hazard;
                end else begin
                    if (len_q != LW'(MIN_PULSE)) len_q <= len_q + LW'(1);
                    spoil_q <= spoil_q | hazard;
                end
            end
        end
    end

    // Byte accepted in the first sampled cycle after the strobe ends
    assign ld_vld = ~wr_act & act_q & ~spoil_q & ~busy & (len_q >= LW'(MIN_PULSE));
endmodule

// File: rtl/eepm_seq.sv
module eepm_seq
    import eepm_pkg::*;
#(
    parameter int BLC_CYC  = 12,
    parameter int PROG_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic ld_vld,
    input  logic wr_act,
    output logic busy,
    output logic commit
);
    localparam int TMAX = (BLC_CYC > PROG_CYC) ? BLC_CYC : PROG_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    eepm_state_t   st_q;
    logic [TW-1:0] tmr_q;

    assign busy   = (st_q == ST_PROG);
    assign commit = busy && (tmr_q == TW'(PROG_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            tmr_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (ld_vld) begin
                    st_q  <= ST_LOAD;
                    tmr_q <= '0;
                end
                ST_LOAD: begin
                    if (ld_vld || wr_act) begin
                        tmr_q <= '0;
                    end else if (tmr_q == TW'(BLC_CYC - 1)) begin
                        st_q  <= ST_PROG;
                        tmr_q <= '0;
                    end else begin
                        tmr_q <= tmr_q + TW'(1);
                    end
                end
                ST_PROG: begin
                    if (commit) begin
                        st_q  <= ST_IDLE;
                        tmr_q <= '0;
                    end else begin
                        tmr_q <= tmr_q + TW'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eepm_pagebuf.sv
module eepm_pagebuf
    import eepm_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int PAGE_AW = 7
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                ld_vld,
    input  logic [ADDR_W-1:0]                   ld_addr,
    input  byte_t                               ld_data,
    input  logic                                commit,
    output logic [ADDR_W-PAGE_AW-1:0]           pg_addr,
    output logic [(1<<PAGE_AW)-1:0][7:0]        pg_data,
    output logic [(1<<PAGE_AW)-1:0]             pg_mask,
    output logic [ADDR_W-1:0]                   last_addr,
    output byte_t                               last_data
);
    localparam int PAGE_BYTES = 1 << PAGE_AW;

    logic [PAGE_AW-1:0] off;
    assign off = ld_addr[PAGE_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_mask   <= '0;
            pg_addr   <= '0;
            last_addr <= '0;
            last_data <= '0;
        end else if (commit) begin
            pg_mask <= '0;
        end else if (ld_vld) begin
            pg_mask[off] <= 1'b1;
            pg_addr      <= ld_addr[ADDR_W-1:PAGE_AW];
            last_addr    <= ld_addr;
            last_data    <= ld_data;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (ld_vld && !commit && off == PAGE_AW'(g)) pg_data[g] <= ld_data;
        end
    end
endmodule

// File: rtl/eepm_array.sv
module eepm_array
    import eepm_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int PAGE_AW = 7
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         commit,
    input  logic [ADDR_W-PAGE_AW-1:0]    pg_addr,
    input  logic [(1<<PAGE_AW)-1:0][7:0] pg_data,
    input  logic [(1<<PAGE_AW)-1:0]      pg_mask,
    input  logic [ADDR_W-1:0]            rd_addr,
    output byte_t                        rd_data
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_AW;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (pg_mask[i]) mem[{pg_addr, PAGE_AW'(i)}] <= pg_data[i];
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_page_model.sv
module eeprom_page_model
    import eepm_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_AW   = 7,
    parameter int BLC_CYC   = 12,
    parameter int PROG_CYC  = 40,
    parameter int MIN_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              supply_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy
);
    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int PG_W       = ADDR_W - PAGE_AW;

    logic                        wr_act, ld_vld, commit;
    logic [ADDR_W-1:0]           ld_addr, last_addr;
    byte_t                       ld_data, last_data, rd_data;
    logic [PG_W-1:0]             pg_addr;
    logic [PAGE_BYTES-1:0][7:0]  pg_data;
    logic [PAGE_BYTES-1:0]       pg_mask;

    eepm_strobe #(.ADDR_W(ADDR_W), .MIN_PULSE(MIN_PULSE)) u_strobe (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .supply_ok(supply_ok), .busy(busy), .addr(addr), .din(din),
        .wr_act(wr_act), .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    eepm_seq #(.BLC_CYC(BLC_CYC), .PROG_CYC(PROG_CYC)) u_seq (
        .clk(clk), .rst(rst), .ld_vld(ld_vld), .wr_act(wr_act),
        .busy(busy), .commit(commit)
    );

    eepm_pagebuf #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) u_pbuf (
        .clk(clk), .rst(rst), .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_data(ld_data),
        .commit(commit), .pg_addr(pg_addr), .pg_data(pg_data), .pg_mask(pg_mask),
        .last_addr(last_addr), .last_data(last_data)
    );

    eepm_array #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) u_arr (
        .clk(clk), .rst(rst), .commit(commit), .pg_addr(pg_addr), .pg_data(pg_data),
        .pg_mask(pg_mask), .rd_addr(addr), .rd_data(rd_data)
    );

    assign dout_en = ~ce_n & ~oe_n & we_n;

    always_comb begin
        if (!dout_en)                      dout = '0;
        else if (busy && addr == last_addr) dout = poll_view(last_data);
        else                               dout = rd_data;
    end
endmodule

// File: rtl/eepm_checker.sv
module eepm_checker #(
    parameter int ADDR_W   = 10,
    parameter int PROG_CYC = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              ld_vld,
    input logic              commit,
    input logic              oe_n,
    input logic              supply_ok,
    input logic [ADDR_W-1:0] last_addr
);
    localparam int CW = $clog2(PROG_CYC + 2);
    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)       busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + CW'(1);
        else           busy_cnt <= '0;
    end

    assert_no_load_busy_R11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ld_vld);

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_cnt == CW'(PROG_CYC));

    assert_load_guard_R8: assert property (@(posedge clk) disable iff (rst)
        ld_vld |-> $past(oe_n));

    assert_load_supply_R10: assert property (@(posedge clk) disable iff (rst)
        ld_vld |-> $past(supply_ok));

    assert_commit_ends_R6: assert property (@(posedge clk) disable iff (rst)
        commit |=> !busy);

    assert_last_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && !commit) |=> $stable(last_addr));
endmodule

bind eeprom_page_model eepm_checker #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .ld_vld(ld_vld), .commit(commit),
    .oe_n(oe_n), .supply_ok(supply_ok), .last_addr(last_addr)
);

// File: tb/tb_eeprom_page_model.sv
module tb_eeprom_page_model;
    localparam int AW    = 10;
    localparam int PAW   = 7;
    localparam int BLC   = 12;
    localparam int PROG  = 40;
    localparam int MINP  = 2;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          ce_n, oe_n, we_n, supply_ok;
    logic [AW-1:0] addr;
    logic [7:0]    din;
    logic [7:0]    dout;
    logic          dout_en, busy;

    int checks = 0;
    int fails  = 0;
    logic [7:0] refm [DEPTH];

    always #5 clk = ~clk;

    eeprom_page_model #(.ADDR_W(AW), .PAGE_AW(PAW), .BLC_CYC(BLC),
                        .PROG_CYC(PROG), .MIN_PULSE(MINP)) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .supply_ok(supply_ok), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    function automatic logic [7:0] polled(input logic [7:0] d);
        return {~d[7], d[6:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    // Strobe of len sampled cycles; returns one inactive cycle after release
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                      input int len = 2, input logic oe = 1'b1, input logic sup = 1'b1);
        addr = a; din = d; oe_n = oe; supply_ok = sup; ce_n = 1'b0; we_n = 1'b0;
        repeat (len) @(negedge clk);
        idle_bus(); supply_ok = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        chk(req, {23'd0, dout_en, dout}, {23'd0, 1'b1, exp});
        @(negedge clk);
        idle_bus();
    endtask

    // Counts cycles until busy rises and how long it stays high
    task automatic run_prog(output int rise_k, output int hi_n);
        rise_k = 0; hi_n = 0;
        while (!busy && rise_k < 4 * BLC) begin @(negedge clk); rise_k++; end
        while (busy && hi_n < 4 * PROG) begin @(negedge clk); hi_n++; end
    endtask

    task automatic no_prog(input string req);
        int seen = 0;
        repeat (BLC + PROG + 4) begin @(negedge clk); if (busy) seen = 1; end
        chk(req, seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int k, n;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) refm[i] = 8'hFF;
        idle_bus(); supply_ok = 1'b1; addr = '0; din = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 dout_en", dout_en, 0);
        rd(10'h000, 8'hFF, "R1 erased");
        rd(10'h3FF, 8'hFF, "R1 erased");

        // R2 output gating: not selected, write strobe, oe high
        addr = 10'h010; ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; #1;
        chk("R2 deselected", {dout_en, dout}, 9'd0);
        ce_n = 1'b0; oe_n = 1'b1; #1;
        chk("R2 oe high", {dout_en, dout}, 9'd0);
        @(negedge clk); idle_bus();

        // R5/R6 single byte, R7 polling held across commit
        wr(10'h1A5, 8'h3C);
        wr(10'h1A6, 8'hC7);
        addr = 10'h1A6; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        for (int c = 1; c <= BLC + PROG + 1; c++) begin
            @(negedge clk);
            if (c == BLC + 5) begin
                addr = 10'h1A5; #1;
                chk("R7 other addr old", dout, 8'hFF);
                addr = 10'h1A6; #1;
            end
            if (c < BLC)            chk("R5 window", {busy, dout}, {1'b0, 8'hFF});
            else if (c < BLC+PROG)  chk("R7 poll", {busy, dout}, {1'b1, polled(8'hC7)});
            else                    chk("R6 true after", {busy, dout}, {1'b0, 8'hC7});
        end
        idle_bus(); @(negedge clk);
        refm[10'h1A5] = 8'h3C; refm[10'h1A6] = 8'hC7;
        rd(10'h1A5, 8'h3C, "R4 page commit");

        // R5 retrigger: second byte just before expiry
        wr(10'h040, 8'h11);
        repeat (BLC - 3) @(negedge clk);
        chk("R5 no early prog", busy, 0);
        wr(10'h041, 8'h22);
        run_prog(k, n);
        chk("R5 restart count", k, BLC);
        chk("R6 length 2 bytes", n, PROG);
        refm[10'h040] = 8'h11; refm[10'h041] = 8'h22;
        rd(10'h040, 8'h11, "R5 first byte kept");

        // R3 address at strobe start, data at last active cycle
        addr = 10'h0F0; din = 8'h01; we_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        addr = 10'h0F3; din = 8'h5A; ce_n = 1'b0;
        @(negedge clk);
        addr = 10'h0F7; din = 8'hA5;
        @(negedge clk);
        din = 8'h77; idle_bus();
        @(negedge clk);
        run_prog(k, n);
        refm[10'h0F3] = 8'hA5;
        rd(10'h0F3, 8'hA5, "R3 captured");
        rd(10'h0F7, 8'hFF, "R3 late addr unused");
        rd(10'h0F0, 8'hFF, "R3 early addr unused");

        // R4 full page, R6 length independent of count, duplicate offset
        for (int b = 0; b < (1 << PAW); b++) wr(AW'(10'h200 + b), 8'(b * 3 + 1));
        wr(10'h205, 8'hEE);
        run_prog(k, n);
        chk("R6 length full page", n, PROG);
        for (int b = 0; b < (1 << PAW); b++) refm[10'h200 + b] = 8'(b * 3 + 1);
        refm[10'h205] = 8'hEE;
        rd(10'h205, 8'hEE, "R4 last value wins");
        rd(10'h27F, refm[10'h27F], "R4 page end");
        rd(10'h280, 8'hFF, "R4 next page untouched");

        // R4 partial page keeps old bytes
        wr(10'h210, 8'h99);
        run_prog(k, n);
        refm[10'h210] = 8'h99;
        rd(10'h210, 8'h99, "R4 partial new");
        rd(10'h211, refm[10'h211], "R4 partial kept");

        // R8 oe low, R9 short pulse, R10 supply low
        wr(10'h300, 8'h12, 2, 1'b0, 1'b1);
        no_prog("R8 no prog");
        rd(10'h300, 8'hFF, "R8 blocked");
        wr(10'h301, 8'h34, MINP - 1);
        no_prog("R9 no prog");
        rd(10'h301, 8'hFF, "R9 blocked");
        wr(10'h302, 8'h56, 3, 1'b1, 1'b0);
        no_prog("R10 no prog");
        rd(10'h302, 8'hFF, "R10 blocked");

        // R11 strobe during programming
        wr(10'h310, 8'h0F);
        while (!busy) @(negedge clk);
        wr(10'h311, 8'hF0, 3);
        while (busy) @(negedge clk);
        no_prog("R11 no second prog");
        refm[10'h310] = 8'h0F;
        rd(10'h311, 8'hFF, "R11 ignored");
        rd(10'h310, 8'h0F, "R11 first ok");

        // Random pages checked against the reference
        for (int it = 0; it < 25; it++) begin
            logic [AW-PAW-1:0] pg;
            int nb;
            pg = (AW-PAW)'($urandom_range(0, (1 << (AW-PAW)) - 1));
            nb = $urandom_range(1, 6);
            for (int j = 0; j < nb; j++) begin
                logic [AW-1:0] a;
                logic [7:0] d;
                a = {pg, PAW'($urandom_range(0, (1 << PAW) - 1))};
                d = 8'($urandom);
                if ($urandom_range(0, 3) == 0) begin
                    wr(a, d, 2, 1'b0, 1'b1);
                end else begin
                    wr(a, d, $urandom_range(MINP, MINP + 2));
                    refm[a] = d;
                end
            end
            run_prog(k, n);
            chk("R6 random length", n, PROG);
            for (int j = 0; j < 3; j++) begin
                logic [AW-1:0] a;
                a = {pg, PAW'($urandom_range(0, (1 << PAW) - 1))};
                rd(a, refm[a], "R4 random read");
            end
            begin
                logic [AW-1:0] a;
                a = AW'($urandom_range(0, DEPTH - 1));
                rd(a, refm[a], "R2 random read");
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule